// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer that steps at a programmable rate. A sub-count of two fine bits sits below the timer, and the two together form a 10-bit time base. Each period starts when the timer has reached the programmed period value and its next step is due. At that point the timer returns to zero, the output goes high, and the 10-bit duty value moves into a shadow copy. The output goes low again when the time base reaches the shadow copy.

Software reaches four fields through a small write port: the period, the upper eight and the lower two duty bits, and a prescale select. Duty writes land in working registers at any time. Only the shadow, which software cannot access, feeds the comparison. A change made part way through a period therefore appears cleanly at the next period start. An enable input starts and stops the generator. While it is low the output is low and the counters rest at zero.

Top module: `pwm_dbuf_top`

## Requirements
- R1: While `en` is low, `pwm_out` is low and the timer and sub-count are held at zero. After reset `pwm_out` is low.
- R2: With prescale factor P (1, 4 or 16) and period value N, one PWM period lasts (N+1)·4·P clock cycles, and periods repeat back to back.
- R3: With a shadowed duty D where 0 < D < (N+1)·4, `pwm_out` is high for the first D·P clock cycles of each period and low for the rest.
- R4: A duty of 0 keeps `pwm_out` low for the whole period. The period-start set is suppressed.
- R5: A duty D ≥ (N+1)·4 never matches the time base, so `pwm_out` stays high for the whole period.
- R6: A duty write that lands inside a period leaves that period unchanged. The new value governs from the next period start on.
- R7: On the first clock edge that samples `en` high, the shadow loads the current duty registers and `pwm_out` goes high (unless the duty is 0). That edge counts as the start of the first period.
- R8: A write happens on a clock edge with `wr_en` high. `wr_sel` selects the field: 0 = period (`wr_data[7:0]`), 1 = duty bits 9..2 (`wr_data[7:0]`), 2 = duty bits 1..0 (`wr_data[1:0]`), 3 = prescale (`wr_data[1:0]`: 0 → ÷1, 1 → ÷4, 2 or 3 → ÷16). The written value applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Field select for the write |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with its default parameters: an 8-bit timer, two fine bits, and prescale shifts up to four. This reaches every prescale code, including the alias code 3. It also reaches the smallest period of four fine counts, where a mid-period duty rewrite has only one free edge, and duty values on either side of the full-period threshold. Random trials keep the period value small so that many prescale and duty combinations fit in the run. One directed trial uses the full 255 period to exercise the widest duty values.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    // Largest prescale shift: divide by 16.
    localparam int PSC_MAX_SHIFT = 4;

    localparam logic [1:0] SEL_PERIOD  = 2'd0;
    localparam logic [1:0] SEL_DUTY_HI = 2'd1;
    localparam logic [1:0] SEL_DUTY_LO = 2'd2;
    localparam logic [1:0] SEL_PSC     = 2'd3;

    typedef enum logic [1:0] {
        PSC_DIV1  = 2'd0,
        PSC_DIV4  = 2'd1,
        PSC_DIV16 = 2'd2
    } psc_e;

    function automatic logic [2:0] psc_shift(psc_e p);
        case (p)
            PSC_DIV1: return 3'd0;
            PSC_DIV4: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    function automatic psc_e psc_decode(logic [1:0] code);
        case (code)
            2'd0:    return PSC_DIV1;
            2'd1:    return PSC_DIV4;
            default: return PSC_DIV16;
        endcase
    endfunction

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [TMR_W-1:0]        wr_data,
    output logic [TMR_W-1:0]        period,
    output logic [TMR_W+FINE_W-1:0] duty,
    output psc_e                    psc
);
    typedef struct packed {
        logic [TMR_W-1:0]  period;
        logic [TMR_W-1:0]  duty_hi;
        logic [FINE_W-1:0] duty_lo;
        psc_e              psc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_PERIOD:  r_d.period  = wr_data;
                SEL_DUTY_HI: r_d.duty_hi = wr_data;
                SEL_DUTY_LO: r_d.duty_lo = wr_data[FINE_W-1:0];
                default:     r_d.psc     = psc_decode(wr_data[1:0]);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign period = r_q.period;
    assign duty   = {r_q.duty_hi, r_q.duty_lo};
    assign psc    = r_q.psc;

    assert_period_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PERIOD) |=> (period == $past(wr_data)));

    assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(duty) && $stable(period)));

endmodule

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase
    import pwm_dbuf_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [TMR_W-1:0]        period,
    input  psc_e                    psc,
    output logic                    load,
    output logic [TMR_W+FINE_W-1:0] tb_next
);
    localparam int SUB_W = FINE_W + PSC_MAX_SHIFT;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [TMR_W-1:0] tmr;
        logic             started;
    } tb_t;

    tb_t t_d, t_q;

    logic [2:0]       shift;
    logic [SUB_W-1:0] sub_last;
    logic [SUB_W-1:0] sub_shifted;
    logic             step_end;
    logic             wrap;

    always_comb begin
        shift    = psc_shift(psc);
        // Sub-count runs 0 .. 2^(FINE_W+shift)-1 per timer step.
        sub_last = {SUB_W{1'b1}} >> (3'(PSC_MAX_SHIFT) - shift);
        step_end = (t_q.sub >= sub_last);
        wrap     = t_q.started && (t_q.tmr == period) && step_end;
        load     = en && (!t_q.started || wrap);

        t_d = t_q;
        if (!en) begin
            t_d = '0;
        end else if (load) begin
            t_d.sub     = '0;
            t_d.tmr     = '0;
            t_d.started = 1'b1;
        end else if (step_end) begin
            t_d.sub = '0;
            t_d.tmr = t_q.tmr + 1'b1;
        end else begin
            t_d.sub = t_q.sub + 1'b1;
        end

        // Fine bits: top FINE_W bits of the active sub-count span.
        sub_shifted = t_d.sub >> shift;
        tb_next     = {t_d.tmr, sub_shifted[FINE_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (t_q.tmr == '0 && t_q.sub == '0 && !t_q.started));

    assert_tmr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && t_q.started && !step_end) |=> $stable(t_q.tmr));

    assert_period_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (t_q.tmr == '0 && t_q.sub == '0));

endmodule

// File: rtl/pwm_dbuf_outstage.sv
module pwm_dbuf_outstage #(
    parameter int TB_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            load,
    input  logic [TB_W-1:0] duty,
    input  logic [TB_W-1:0] tb_next,
    output logic            pwm_out
);
    typedef struct packed {
        logic [TB_W-1:0] shadow;
        logic            out;
    } os_t;

    os_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (!en) begin
            o_d.out = 1'b0;
        end else if (load) begin
            o_d.shadow = duty;
            o_d.out    = (duty != '0);
        end else if (tb_next == o_q.shadow) begin
            o_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pwm_out = o_q.out;

    assert_off_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !o_q.out);

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(o_q.shadow));

    assert_rise_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_q.out) |-> $past(load));

    assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && duty == '0) |=> !o_q.out);

endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
    import pwm_dbuf_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [TMR_W-1:0] wr_data,
    output logic             pwm_out
);
    localparam int TB_W = TMR_W + FINE_W;

    logic [TMR_W-1:0] period;
    logic [TB_W-1:0]  duty;
    psc_e             psc;
    logic             load;
    logic [TB_W-1:0]  tb_next;

    pwm_dbuf_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .period  (period),
        .duty    (duty),
        .psc     (psc)
    );

    pwm_dbuf_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .period  (period),
        .psc     (psc),
        .load    (load),
        .tb_next (tb_next)
    );

    pwm_dbuf_outstage #(.TB_W(TB_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (load),
        .duty    (duty),
        .tb_next (tb_next),
        .pwm_out (pwm_out)
    );

endmodule

// File: tb/sim_pwm_dbuf_top.sv
module sim_pwm_dbuf_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    pwm_dbuf_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(logic got, logic exp, string req, int idx);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s sample %0d actual %0b expected %0b", req, idx, got, exp);
        end
    endtask

    function automatic int p_of(int code);
        if (code == 0) return 1;
        if (code == 1) return 4;
        return 16;
    endfunction

    // R3/R4/R5: high for the first D*P cycles of a period of length T.
    function automatic logic exp_level(int ph, int d, int p);
        return (ph < d * p) ? 1'b1 : 1'b0;
    endfunction

    function automatic string tag_of(int d, int p, int t, int i);
        if (i == 0)     return "R7";
        if (d == 0)     return "R4";
        if (d * p >= t) return "R5";
        return "R3 R2";
    endfunction

    task automatic wr(int sel, int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = 2'(sel);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic trial(int pr, int pc, int d_old, bit swap, int d_new, string pre);
        int p, t, n, s, d;
        en = 1'b0;
        wr(0, pr);
        wr(1, d_old >> 2);
        wr(2, d_old & 3);
        wr(3, pc);
        p = p_of(pc);
        t = (pr + 1) * 4 * p;
        n = swap ? 3 * t : 2 * t;
        s = t / 2 - 1;
        @(negedge clk);
        en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            d = (swap && i >= t) ? d_new : d_old;
            check(pwm_out, exp_level(i % t, d, p),
                  swap ? {pre, " R6"} : {pre, " ", tag_of(d, p, t, i)}, i);
            if (swap && i == s) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'(d_new >> 2);
            end else if (swap && i == s + 1) begin
                wr_sel = 2'd2; wr_data = 8'(d_new & 3);
            end else if (swap && i == s + 2) begin
                wr_en = 1'b0;
            end
        end
        en = 1'b0;
        @(negedge clk);
        check(pwm_out, 1'b0, "R1 disable", -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pr, pc, d, dn, full, r;
        bit sw;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check(pwm_out, 1'b0, "R1 reset", -1);
        rst_n = 1'b1;

        // R1: disabled output stays low with a nonzero duty programmed.
        wr(0, 3); wr(1, 8'h19); wr(2, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(pwm_out, 1'b0, "R1 idle", i);
        end

        // Directed corner cases.
        trial(0, 0, 1, 0, 0, "dir");       // smallest period, width 1
        trial(0, 0, 3, 0, 0, "dir");       // one below full
        trial(0, 0, 4, 0, 0, "dir");       // exactly full (R5)
        trial(0, 0, 0, 0, 0, "dir");       // zero duty (R4)
        trial(3, 1, 15, 0, 0, "dir");      // /4, one below full
        trial(3, 1, 16, 0, 0, "dir");      // /4, exactly full
        trial(1, 3, 5, 0, 0, "R8 code3");  // prescale code 3 aliases /16
        trial(0, 0, 1, 1, 3, "dir");       // smallest period, mid-period rewrite
        trial(2, 2, 6, 1, 0, "dir");       // rewrite to zero
        trial(255, 0, 1023, 0, 0, "dir");  // widest duty value

        // Random trials.
        for (int k = 0; k < 24; k++) begin
            pr   = $urandom_range(0, 15);
            pc   = $urandom_range(0, 3);
            full = (pr + 1) * 4;
            r    = $urandom_range(0, 4);
            if (r == 0)      d = 0;
            else if (r == 1) d = full + $urandom_range(0, 20);
            else             d = $urandom_range(1, full - 1);
            sw = 1'($urandom_range(0, 1));
            dn = $urandom_range(0, full + 2);
            trial(pr, pc, d, sw, dn, "rnd");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule